// File: doc/BRIEF.md
# Range-Guarded Load/Store Unit

This block carries out register-to-memory and memory-to-register transfers of 1, 2, 4 or 8 bytes against a little-endian data memory organised as 64-bit words, whose size in bytes is a parameter. The request gives an opcode, a base value, a 48-bit offset and, for stores, the data to write. The unit adds base and offset to form the byte address. It then checks the full extent of the access against the memory size before it drives the single-cycle synchronous memory port, which has per-byte write enables.

A request is one cycle long. One cycle after a load, the zero-extended result leaves on a register write-back port together with its destination index. If the access would touch any byte at or beyond the end of memory, the unit drives no memory activity. In the following cycle it raises memory-fault trap number 4, reports the offending address, and writes that address into register 15 through the same write-back port. The surrounding pipeline decodes the fields of each instruction word. For a store it passes the register named in the destination field as the base and the first source register as the data.

Top module: `bounded_lsu`

## Requirements
- R1: Opcodes 0x20, 0x21, 0x22 and 0x23 load 1, 2, 4 and 8 bytes. The bytes are assembled little-endian (lowest address in bits 7:0) and zero-extended to 64 bits. In the cycle after the request they appear on wb_data with wb_valid high and wb_idx equal to req_rd.
- R2: Opcodes 0x24, 0x25, 0x26 and 0x27 store the low 1, 2, 4 and 8 bytes of req_wdata. Only those bytes of memory change, and later loads read them back in little-endian order.
- R3: The byte address is req_base plus the 48-bit req_imm sign-extended to 64 bits, taken modulo 2^64.
- R4: An access is in range only when address plus access size in bytes, computed without wrap-around, is no greater than MEM_BYTES. An access ending exactly at MEM_BYTES is legal, and one byte further faults.
- R5: One cycle after an out-of-range request, trap_valid is high, trap_code is 4 and trap_addr holds the byte address.
- R6: On a fault the write-back port carries wb_idx 15 and wb_data equal to the faulting address.
- R7: A faulting request drives mem_en low and mem_be to zero in its cycle. Memory therefore keeps its contents, and a faulting load writes nothing to its destination register.
- R8: Address bits below the access size are disregarded, so an access uses the naturally aligned lanes that contain the address. For an in-range access, mem_addr is address bits above bit 2, and mem_be covers exactly the access's lanes.
- R9: Any opcode outside 0x20 to 0x27 causes no memory access, no write-back and no trap.
- R10: After reset, with no request pending, wb_valid, trap_valid and mem_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 8 | Opcode |
| req_rd | input | 4 | Destination register index for loads |
| req_base | input | 64 | Base address value |
| req_imm | input | 48 | Signed offset |
| req_wdata | input | 64 | Store data |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | WORD_AW | 64-bit word index |
| mem_be | output | 8 | Byte lane enables |
| mem_wdata | output | 64 | Write data placed in lanes |
| mem_rdata | input | 64 | Read word, valid the cycle after a read |
| wb_valid | output | 1 | Register write-back strobe |
| wb_idx | output | 4 | Register written |
| wb_data | output | 64 | Value written |
| trap_valid | output | 1 | Memory-fault trap raised |
| trap_code | output | 8 | Trap number (4 when raised) |
| trap_addr | output | 64 | Faulting byte address |

## Verification
Directed transfers put distinct byte patterns in every lane, so any swap of lanes, mis-shift or missing zero extension shows up in the value read back. Addresses placed at the last legal start of each width, and one byte past it, tell an inclusive range check from an exclusive one. A negative offset and a base near 2^64 separate a sign-extended offset from a zero-extended one and a wrapping end test from one that does not wrap. A faulting store followed by a load of the same word shows whether enables leaked out. The constrained random phase mixes widths, unaligned addresses, and bases that fall both inside and outside memory, and it checks each write-back against a byte-level model of memory.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam logic [7:0] TRAP_MEM_FAULT = 8'd4;
  localparam logic [3:0] FAULT_REG      = 4'd15;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} size_e;

  typedef struct packed {
    logic  is_load;
    logic  is_store;
    size_e size;
  } op_dec_t;

  function automatic op_dec_t decode_op(logic [7:0] op);
    op_dec_t d;
    d.is_load  = (op[7:2] == 6'b001000);
    d.is_store = (op[7:2] == 6'b001001);
    d.size     = size_e'(op[1:0]);
    return d;
  endfunction

  function automatic logic [3:0] size_bytes(size_e s);
    return 4'd1 << s;
  endfunction

  // lane of the naturally aligned container of the access
  function automatic logic [2:0] lane_of(logic [2:0] lo, size_e s);
    case (s)
      SZ_B:    return lo;
      SZ_H:    return {lo[2:1], 1'b0};
      SZ_W:    return {lo[2], 2'b00};
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [7:0] enables_of(logic [2:0] lane, size_e s);
    case (s)
      SZ_B:    return 8'h01 << lane;
      SZ_H:    return 8'h03 << lane;
      SZ_W:    return 8'h0F << lane;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [63:0] pick_lanes(logic [63:0] w, logic [2:0] lane, size_e s);
    logic [63:0] sh;
    sh = w >> {lane, 3'b000};
    case (s)
      SZ_B:    return {56'd0, sh[7:0]};
      SZ_H:    return {48'd0, sh[15:0]};
      SZ_W:    return {32'd0, sh[31:0]};
      default: return sh;
    endcase
  endfunction

endpackage

// File: rtl/lsu_addr_check.sv
module lsu_addr_check
  import lsu_pkg::*;
#(
  parameter longint unsigned MEM_BYTES = 4096
) (
  input  logic [63:0] base,
  input  logic [47:0] imm,
  input  size_e       size,
  output logic [63:0] ea,
  output logic        out_of_range
);
  logic [64:0] end_excl;

  always_comb begin
    ea           = base + {{16{imm[47]}}, imm};
    end_excl     = {1'b0, ea} + {61'd0, size_bytes(size)};
    out_of_range = end_excl > 65'(MEM_BYTES);
  end
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
  import lsu_pkg::*;
(
  input  logic [2:0]  addr_lo,
  input  size_e       size,
  input  logic        enable,
  input  logic [63:0] src,
  output logic [2:0]  lane,
  output logic [7:0]  be,
  output logic [63:0] placed
);
  always_comb begin
    lane   = lane_of(addr_lo, size);
    be     = enable ? enables_of(lane, size) : 8'h00;
    placed = src << {lane, 3'b000};
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
(
  input  logic [63:0] word,
  input  logic [2:0]  lane,
  input  size_e       size,
  output logic [63:0] value
);
  always_comb value = pick_lanes(word, lane, size);
endmodule

// File: rtl/bounded_lsu.sv
module bounded_lsu
  import lsu_pkg::*;
#(
  parameter  longint unsigned MEM_BYTES = 4096,
  localparam int              WORD_AW   = $clog2(MEM_BYTES / 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [7:0]         req_op,
  input  logic [3:0]         req_rd,
  input  logic [63:0]        req_base,
  input  logic [47:0]        req_imm,
  input  logic [63:0]        req_wdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [7:0]         mem_be,
  output logic [63:0]        mem_wdata,
  input  logic [63:0]        mem_rdata,
  output logic               wb_valid,
  output logic [3:0]         wb_idx,
  output logic [63:0]        wb_data,
  output logic               trap_valid,
  output logic [7:0]         trap_code,
  output logic [63:0]        trap_addr
);
  op_dec_t     dec;
  logic        acc_is_mem;
  logic        acc_fault;
  logic [63:0] acc_ea;
  logic [2:0]  acc_lane;

  logic        rsp_load, rsp_fault;
  logic [3:0]  rsp_rd;
  size_e       rsp_size;
  logic [2:0]  rsp_lane;
  logic [63:0] rsp_ea;
  logic [63:0] rsp_value;

  always_comb begin
    dec        = decode_op(req_op);
    acc_is_mem = req_valid && (dec.is_load || dec.is_store);
  end

  lsu_addr_check #(.MEM_BYTES(MEM_BYTES)) u_check (
    .base        (req_base),
    .imm         (req_imm),
    .size        (dec.size),
    .ea          (acc_ea),
    .out_of_range(acc_fault)
  );

  always_comb begin
    mem_en   = acc_is_mem && !acc_fault;
    mem_we   = mem_en && dec.is_store;
    mem_addr = acc_ea[WORD_AW+2:3];
  end

  lsu_lane_map u_lanes (
    .addr_lo(acc_ea[2:0]),
    .size   (dec.size),
    .enable (mem_en),
    .src    (req_wdata),
    .lane   (acc_lane),
    .be     (mem_be),
    .placed (mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_load  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rd    <= 4'd0;
      rsp_size  <= SZ_B;
      rsp_lane  <= 3'd0;
      rsp_ea    <= 64'd0;
    end else begin
      rsp_load  <= acc_is_mem && !acc_fault && dec.is_load;
      rsp_fault <= acc_is_mem && acc_fault;
      rsp_rd    <= req_rd;
      rsp_size  <= dec.size;
      rsp_lane  <= acc_lane;
      rsp_ea    <= acc_ea;
    end
  end

  lsu_load_align u_align (
    .word (mem_rdata),
    .lane (rsp_lane),
    .size (rsp_size),
    .value(rsp_value)
  );

  always_comb begin
    wb_valid   = rsp_load || rsp_fault;
    wb_idx     = rsp_fault ? FAULT_REG : rsp_rd;
    wb_data    = rsp_fault ? rsp_ea : rsp_value;
    trap_valid = rsp_fault;
    trap_code  = rsp_fault ? TRAP_MEM_FAULT : 8'd0;
    trap_addr  = rsp_fault ? rsp_ea : 64'd0;
  end
endmodule

// File: rtl/bounded_lsu_chk.sv
module bounded_lsu_chk #(
  parameter  longint unsigned MEM_BYTES = 4096,
  localparam int              WORD_AW   = $clog2(MEM_BYTES / 8)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               acc_is_mem,
  input logic               acc_fault,
  input logic [63:0]        acc_ea,
  input logic               mem_en,
  input logic               mem_we,
  input logic [WORD_AW-1:0] mem_addr,
  input logic [7:0]         mem_be,
  input logic               wb_valid,
  input logic [3:0]         wb_idx,
  input logic [63:0]        wb_data,
  input logic               trap_valid,
  input logic [7:0]         trap_code,
  input logic [63:0]        trap_addr
);
  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_is_mem && acc_fault) |-> (!mem_en && mem_be == 8'h00));

  // R5
  trap_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_is_mem && acc_fault) |=> (trap_valid && trap_code == 8'd4 && trap_addr == $past(acc_ea)));

  // R6
  fault_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (wb_valid && wb_idx == 4'd15 && wb_data == trap_addr));

  // R1
  load_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (wb_valid && !trap_valid));

  // R8
  lanes_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ($countones(mem_be) == 1 || mem_be == 8'h03 || mem_be == 8'h0C ||
                mem_be == 8'h30 || mem_be == 8'hC0 || mem_be == 8'h0F ||
                mem_be == 8'hF0 || mem_be == 8'hFF));

  // R4
  in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (64'(mem_addr) < MEM_BYTES / 8));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!wb_valid && !trap_valid));
endmodule

bind bounded_lsu bounded_lsu_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .acc_is_mem(acc_is_mem),
  .acc_fault (acc_fault),
  .acc_ea    (acc_ea),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .wb_valid  (wb_valid),
  .wb_idx    (wb_idx),
  .wb_data   (wb_data),
  .trap_valid(trap_valid),
  .trap_code (trap_code),
  .trap_addr (trap_addr)
);

// File: tb/test_bounded_lsu.sv
`timescale 1ns/1ps
module test_bounded_lsu;
  localparam longint unsigned MB = 4096;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_op = 8'd0;
  logic [3:0] req_rd = 4'd0;
  logic [63:0] req_base = 64'd0;
  logic [47:0] req_imm = 48'd0;
  logic [63:0] req_wdata = 64'd0;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_be;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata;
  logic wb_valid, trap_valid;
  logic [3:0] wb_idx;
  logic [63:0] wb_data, trap_addr;
  logic [7:0] trap_code;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bounded_lsu i_bounded_lsu (.*);

  logic [63:0] words [0:511];
  logic [7:0]  ref_mem [0:4095];

  always @(posedge clk) begin
    if (mem_en) begin
      for (int b = 0; b < 8; b++)
        if (mem_we && mem_be[b]) words[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      mem_rdata <= words[mem_addr];
    end
  end

  function automatic logic [63:0] exp_ea(logic [63:0] base, logic [47:0] imm);
    logic [63:0] off;
    off = {{16{imm[47]}}, imm};
    return base + off;
  endfunction

  function automatic bit exp_fault(logic [63:0] ea, int nbytes);
    logic [64:0] e;
    e = {1'b0, ea} + 65'(nbytes);
    return e > 65'(MB);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(logic [7:0] op, logic [3:0] rd, logic [63:0] base,
                       logic [47:0] imm, logic [63:0] wdata);
    logic [63:0] ea, start, exp_val;
    int nb;
    bit isld, isst, flt;
    isld = (op[7:2] == 6'b001000);
    isst = (op[7:2] == 6'b001001);
    nb = 1 << op[1:0];
    ea = exp_ea(base, imm);
    flt = (isld || isst) && exp_fault(ea, nb);
    start = ea & ~(64'(nb) - 64'd1);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_rd = rd;
    req_base = base; req_imm = imm; req_wdata = wdata;
    #1;
    if (flt) begin
      chk("R7 fault mem_en", {63'd0, mem_en}, 64'd0);
      chk("R7 fault mem_be", {56'd0, mem_be}, 64'd0);
    end else if (!(isld || isst)) begin
      chk("R9 no access", {63'd0, mem_en}, 64'd0);
    end else begin
      chk("R8 word index", {55'd0, mem_addr}, {3'd0, ea[63:3]} & 64'h1FF);
      chk("R8 byte enables", {56'd0, mem_be}, 64'((((1 << nb) - 1) << start[2:0]) & 8'hFF));
    end
    if (isst && !flt)
      for (int i = 0; i < nb; i++) ref_mem[start + 64'(i)] = wdata[i*8 +: 8];
    exp_val = 64'd0;
    if (isld && !flt)
      for (int i = 0; i < nb; i++) exp_val[i*8 +: 8] = ref_mem[start + 64'(i)];
    @(negedge clk);
    req_valid = 1'b0;
    if (flt) begin
      chk("R5 trap_valid", {63'd0, trap_valid}, 64'd1);
      chk("R5 trap_code", {56'd0, trap_code}, 64'd4);
      chk("R5 trap_addr", trap_addr, ea);
      chk("R6 wb_idx", {60'd0, wb_idx}, 64'd15);
      chk("R6 wb_data", wb_data, ea);
    end else if (isld) begin
      chk("R1 wb_valid", {63'd0, wb_valid}, 64'd1);
      chk("R1 wb_idx", {60'd0, wb_idx}, {60'd0, rd});
      chk("R1 load data", wb_data, exp_val);
    end else begin
      chk("R9 no write-back", {62'd0, wb_valid, trap_valid}, 64'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) words[i] = 64'd0;
    for (int i = 0; i < 4096; i++) ref_mem[i] = 8'd0;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 idle outputs", {61'd0, wb_valid, trap_valid, mem_en}, 64'd0);

    // R2 store double, R1 loads at every width and lane
    do_op(8'h27, 4'd1, 64'd64, 48'd0, 64'h8877665544332211);
    do_op(8'h23, 4'd2, 64'd64, 48'd0, 64'd0);
    do_op(8'h20, 4'd3, 64'd60, 48'd7, 64'd0);
    do_op(8'h21, 4'd4, 64'd70, 48'd0, 64'd0);
    do_op(8'h22, 4'd5, 64'd68, 48'd0, 64'd0);
    // R8 unaligned half and word use the containing aligned lanes
    do_op(8'h21, 4'd6, 64'd71, 48'd0, 64'd0);
    do_op(8'h22, 4'd7, 64'd66, 48'd0, 64'd0);
    // R2 narrow stores touch only their bytes
    do_op(8'h24, 4'd0, 64'd67, 48'd0, 64'hFFFFFFFFFFFFFFAB);
    do_op(8'h25, 4'd0, 64'd68, 48'd0, 64'hFFFFFFFFFFFFCDEF);
    do_op(8'h26, 4'd0, 64'd64, 48'd0, 64'hFFFFFFFF01020304);
    do_op(8'h23, 4'd8, 64'd64, 48'd0, 64'd0);
    // R3 negative offset
    do_op(8'h23, 4'd9, 64'd100, 48'hFFFF_FFFF_FFDC, 64'd0);
    // R4 boundaries
    do_op(8'h23, 4'd1, 64'd4088, 48'd0, 64'd0);
    do_op(8'h23, 4'd1, 64'd4089, 48'd0, 64'd0);
    do_op(8'h20, 4'd1, 64'd4095, 48'd0, 64'd0);
    do_op(8'h20, 4'd1, 64'd4096, 48'd0, 64'd0);
    do_op(8'h22, 4'd1, 64'd4090, 48'd2, 64'd0);
    do_op(8'h22, 4'd1, 64'd4090, 48'd3, 64'd0);
    // R4 no wrap on a huge base
    do_op(8'h23, 4'd1, 64'hFFFF_FFFF_FFFF_FFFC, 48'd0, 64'd0);
    // R3 offset wraps the sum to a small legal address
    do_op(8'h20, 4'd2, 64'hFFFF_FFFF_FFFF_FFF8, 48'd72, 64'd0);
    // R7 faulting store leaves memory intact
    do_op(8'h27, 4'd0, 64'd4092, 48'd0, 64'hDEADBEEFDEADBEEF);
    do_op(8'h23, 4'd3, 64'd4088, 48'd0, 64'd0);
    // R9 other opcodes
    do_op(8'h28, 4'd1, 64'd64, 48'd0, 64'd0);
    do_op(8'h1F, 4'd1, 64'd64, 48'd0, 64'd0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      logic [63:0] base;
      logic [47:0] imm;
      op = 8'h20 + 8'($urandom_range(0, 7));
      base = 64'($urandom_range(0, 4200));
      imm = 48'($signed(16'($urandom_range(0, 255)) - 16'sd128));
      do_op(op, 4'($urandom_range(0, 15)), base, imm, {$urandom, $urandom});
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule